// File: doc/BRIEF.md
# USB Host Port Status and Control

This block holds the status and control state of one root port in a USB 2.0 enhanced host controller. It decides whether the enhanced controller or a companion controller owns the port. It reports the D+/D- line levels so that software can tell whether a newly attached device is low-speed. It also runs the bus reset that software starts and stops through the port register.

Software reads and writes a single 16-bit port register. A write strobe applies a whole word to the writable fields. The read word is formed combinationally from the live state and the PHY inputs.

When software releases the reset bit, the reset does not end at once. The block keeps driving reset for a fixed tail of `TAIL_CYC` clocks. The reset bit keeps reading 1 until that tail has finished. At the end of the tail, the port becomes enabled only if the PHY reports a high-speed device. If the controller is halted, the tail is paused and the reset bit is held at 1.

Top module: `usb_port_ctrl`

## Requirements
- R1: While `cfg_flag` is 0, including during reset, `port_owner` and read bit 13 are 1, and writes to bit 13 are ignored.
- R2: On the first clock at which `cfg_flag` is seen as 1 after being 0, `port_owner` clears to 0.
- R3: With `cfg_flag` held at 1, a register write copies write bit 13 into `port_owner` (1 hands the port to the companion controller).
- R4: Read bit 12 always reads 1. Read bit 9 and bits 15:14, 7:3 and 1 read 0. Bit 0 shows `connect`, bit 2 shows `port_en` and bit 8 shows `reset_active`.
- R5: Read bits 11:10 show D+ in bit 11 and D- in bit 10 (00 SE0, 10 J, 01 K, 11 undefined). They show the lines only while `connect` is 1 and `port_en` is 0, and read 00 otherwise.
- R6: A write with bit 8 set while no reset is active starts a reset on the next clock. `reset_active` and `drive_reset` go to 1 and `port_en` goes to 0, whatever write bit 2 holds.
- R7: A write with bit 8 clear during reset starts the tail. `reset_active` stays 1 for exactly `TAIL_CYC` further unhalted clocks and then falls with `drive_reset`.
- R8: At the clock where the tail ends, `port_en` takes the value of `hs_detect`. `port_en` never rises at any other time. The tail never exceeds 2 ms (`2*CLKS_PER_MS` unhalted clocks).
- R9: A reset that ends without `hs_detect` leaves `port_en` at 0 and does not change `port_owner`.
- R10: While `halted` is 1 during the tail, the tail count stops, `reset_active` stays 1 and `drive_reset` is 0.
- R11: A write with bit 2 clear disables the port. A write with bit 2 set never enables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_flag | input | 1 | Controller configured flag |
| halted | input | 1 | Controller halted flag |
| connect | input | 1 | Current connect status from PHY |
| line_dp | input | 1 | D+ logic level |
| line_dm | input | 1 | D- logic level |
| hs_detect | input | 1 | PHY reports a high-speed device |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| port_en | output | 1 | Port enabled |
| port_owner | output | 1 | 1 = companion controller owns the port |
| reset_active | output | 1 | Reset bit as seen by software |
| drive_reset | output | 1 | Request to the PHY to drive bus reset |

## Verification
A wrong ownership state shows on `port_owner` and read bit 13 one clock after the configured flag changes or after a write. A miscounted tail moves the falling edge of bit 8 away from exactly `TAIL_CYC` clocks after the release write. A lost halt hold shows as that edge arriving while `halted` is still high. A wrong enable decision shows on `port_en` in the same clock that the reset bit falls. A wrong enable decision also changes whether the line-status field is masked.

// File: rtl/usb_port_pkg.sv
package usb_port_pkg;
  localparam int PB_CONN = 0;
  localparam int PB_EN   = 2;
  localparam int PB_RST  = 8;
  localparam int PB_RSV  = 9;
  localparam int PB_DM   = 10;
  localparam int PB_DP   = 11;
  localparam int PB_PWR  = 12;
  localparam int PB_OWN  = 13;
  localparam int REG_W   = 16;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_DRIVE = 2'd1,
    RS_TAIL  = 2'd2
  } rst_state_e;
endpackage

// File: rtl/port_owner_ctl.sv
module port_owner_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_flag,
  input  logic wr_en,
  input  logic wr_own,
  output logic owner
);
  logic cfg_q;
  logic owner_d;

  always_comb begin
    owner_d = owner;
    if (!cfg_flag)      owner_d = 1'b1;
    else if (!cfg_q)    owner_d = 1'b0;
    else if (wr_en)     owner_d = wr_own;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= 1'b0;
      owner <= 1'b1;
    end else begin
      cfg_q <= cfg_flag;
      owner <= owner_d;
    end
  end

  assert_owner_forced_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_flag |=> owner);
  assert_owner_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flag && !cfg_q) |=> !owner);
  assert_owner_written_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flag && cfg_q && wr_en) |=> (owner == $past(wr_own)));
endmodule

// File: rtl/port_reset_seq.sv
module port_reset_seq #(
  parameter int TAIL_CYC = 60000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_rst,
  input  logic wr_en_bit,
  input  logic halted,
  input  logic hs_detect,
  output logic rst_bit,
  output logic drive_rst,
  output logic port_en
);
  import usb_port_pkg::*;

  localparam int CW = $clog2(TAIL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TAIL_CYC - 1);

  rst_state_e st, st_d;
  logic [CW-1:0] cnt, cnt_d;
  logic cnt_ce;
  logic en_d;

  always_comb begin
    st_d   = st;
    cnt_d  = cnt;
    cnt_ce = 1'b0;
    en_d   = port_en;
    case (st)
      RS_IDLE: begin
        if (wr_en && wr_rst) begin
          st_d = RS_DRIVE;
          en_d = 1'b0;
        end else if (wr_en && !wr_en_bit) begin
          en_d = 1'b0;
        end
      end
      RS_DRIVE: begin
        if (wr_en && !wr_rst) begin
          st_d   = RS_TAIL;
          cnt_d  = '0;
          cnt_ce = 1'b1;
        end
      end
      RS_TAIL: begin
        if (!halted) begin
          if (cnt == LAST) begin
            st_d = RS_IDLE;
            en_d = hs_detect;
          end else begin
            cnt_d  = cnt + 1'b1;
            cnt_ce = 1'b1;
          end
        end
      end
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RS_IDLE;
      cnt     <= '0;
      port_en <= 1'b0;
    end else begin
      st      <= st_d;
      port_en <= en_d;
      if (cnt_ce) cnt <= cnt_d;
    end
  end

  assign rst_bit   = (st != RS_IDLE);
  assign drive_rst = (st == RS_DRIVE) || ((st == RS_TAIL) && !halted);

  assert_reset_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_rst && st == RS_IDLE) |=> (rst_bit && drive_rst && !port_en));
  assert_release_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RS_DRIVE && wr_en && !wr_rst) |=> rst_bit);
  assert_enable_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_en) |-> ($past(st) == RS_TAIL && st == RS_IDLE));
  assert_halt_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RS_TAIL && halted) |=> rst_bit);
endmodule

// File: rtl/port_line_sense.sv
module port_line_sense (
  input  logic       connect,
  input  logic       port_en,
  input  logic       line_dp,
  input  logic       line_dm,
  output logic [1:0] lstat
);
  always_comb begin
    if (connect && !port_en) lstat = {line_dp, line_dm};
    else                     lstat = 2'b00;
  end
endmodule

// File: rtl/usb_port_ctrl.sv
module usb_port_ctrl #(
  parameter int CLKS_PER_MS = 60000,
  parameter int TAIL_CYC    = 60000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_flag,
  input  logic        halted,
  input  logic        connect,
  input  logic        line_dp,
  input  logic        line_dm,
  input  logic        hs_detect,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        port_en,
  output logic        port_owner,
  output logic        reset_active,
  output logic        drive_reset
);
  import usb_port_pkg::*;

  localparam int LIMIT = 2 * CLKS_PER_MS;
  localparam int LW    = $clog2(LIMIT + 2);

  logic [1:0] rst_sync;
  logic       rst_n_s;
  logic [1:0] lstat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  port_owner_ctl u_owner (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cfg_flag (cfg_flag),
    .wr_en    (reg_wr),
    .wr_own   (reg_wdata[PB_OWN]),
    .owner    (port_owner)
  );

  port_reset_seq #(.TAIL_CYC(TAIL_CYC)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (reg_wr),
    .wr_rst    (reg_wdata[PB_RST]),
    .wr_en_bit (reg_wdata[PB_EN]),
    .halted    (halted),
    .hs_detect (hs_detect),
    .rst_bit   (reset_active),
    .drive_rst (drive_reset),
    .port_en   (port_en)
  );

  port_line_sense u_line (
    .connect (connect),
    .port_en (port_en),
    .line_dp (line_dp),
    .line_dm (line_dm),
    .lstat   (lstat)
  );

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[PB_CONN] = connect;
    reg_rdata[PB_EN]   = port_en;
    reg_rdata[PB_RST]  = reset_active;
    reg_rdata[PB_RSV]  = 1'b0;
    reg_rdata[PB_DM]   = lstat[0];
    reg_rdata[PB_DP]   = lstat[1];
    reg_rdata[PB_PWR]  = 1'b1;
    reg_rdata[PB_OWN]  = port_owner;
  end

  // Settle-time watch: unhalted clocks between software release and reset end.
  logic          sw_rel;
  logic [LW-1:0] settle_cnt;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sw_rel     <= 1'b0;
      settle_cnt <= '0;
    end else begin
      if (!reset_active) begin
        sw_rel     <= 1'b0;
        settle_cnt <= '0;
      end else begin
        if (reg_wr && !reg_wdata[PB_RST]) sw_rel <= 1'b1;
        if (sw_rel && !halted && settle_cnt <= LW'(LIMIT)) settle_cnt <= settle_cnt + 1'b1;
      end
    end
  end

  assert_settle_limit_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    settle_cnt <= LW'(LIMIT));
  assert_no_hs_no_enable_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($fell(reset_active) && !$past(hs_detect)) |-> !port_en);
endmodule

// File: tb/usb_port_ctrl_bench.sv
module usb_port_ctrl_bench;
  localparam int CPM  = 10;
  localparam int TAIL = 6;

  logic clk = 1'b0;
  logic rst_n, cfg_flag, halted, connect, line_dp, line_dm, hs_detect, reg_wr;
  logic [15:0] reg_wdata, reg_rdata;
  logic port_en, port_owner, reset_active, drive_reset;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  usb_port_ctrl #(.CLKS_PER_MS(CPM), .TAIL_CYC(TAIL)) u_usb_port_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_flag(cfg_flag), .halted(halted),
    .connect(connect), .line_dp(line_dp), .line_dm(line_dm),
    .hs_detect(hs_detect), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .port_en(port_en), .port_owner(port_owner),
    .reset_active(reset_active), .drive_reset(drive_reset)
  );

  // {connect, dp, dm, expected field[1:0]}
  localparam logic [4:0] LVEC [6] = '{5'b1_00_00, 5'b1_10_10, 5'b1_01_01,
                                     5'b1_11_11, 5'b0_10_00, 5'b0_01_00};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_flag = 0; halted = 0; connect = 0; line_dp = 0; line_dm = 0;
    hs_detect = 0; reg_wr = 0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset owner", port_owner, 1);
    chk("R4 reset read word", reg_rdata, 16'h3000);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R5 line-status table
    for (int i = 0; i < 6; i++) begin
      connect = LVEC[i][4]; line_dp = LVEC[i][3]; line_dm = LVEC[i][2];
      #2;
      chk("R5 line field", reg_rdata[11:10], LVEC[i][1:0]);
      chk("R4 fixed bits", reg_rdata & 16'hD2FB, 16'h1000 | 16'(connect));
      @(negedge clk);
    end

    // Ownership
    wr(16'h0000);
    chk("R1 write ignored while unconfigured", port_owner, 1);
    @(negedge clk); cfg_flag = 1; @(negedge clk);
    chk("R2 owner cleared on configure", port_owner, 0);
    wr(16'h2000);
    chk("R3 owner written 1", reg_rdata[13], 1);
    wr(16'h0000);
    chk("R3 owner written 0", port_owner, 0);
    cfg_flag = 0; @(negedge clk);
    chk("R1 owner forced", port_owner, 1);
    cfg_flag = 1; @(negedge clk);
    chk("R2 owner cleared again", port_owner, 0);

    // Enable cannot be set by software
    wr(16'h0004);
    chk("R11 write 1 to enable ignored", port_en, 0);

    // High-speed reset path
    connect = 1; hs_detect = 1; line_dp = 0; line_dm = 0;
    wr(16'h0104);
    chk("R6 reset bit set", reset_active, 1);
    chk("R6 drive", drive_reset, 1);
    chk("R6 enable cleared", port_en, 0);
    repeat (5) @(negedge clk);
    wr(16'h0000);
    chk("R7 bit held after release", reg_rdata[8], 1);
    repeat (TAIL - 1) @(negedge clk);
    chk("R7 bit still held at tail end-1", reset_active, 1);
    @(negedge clk);
    chk("R7 bit falls after tail", reset_active, 0);
    chk("R7 drive stops", drive_reset, 0);
    chk("R8 high-speed enables", port_en, 1);
    line_dm = 1; #2;
    chk("R5 masked while enabled", reg_rdata[11:10], 0);
    wr(16'h0004);
    chk("R11 enable kept by write 1", port_en, 1);
    wr(16'h0000);
    chk("R11 enable cleared by write 0", port_en, 0);

    // Full-speed path: J state seen, reset, no enable
    hs_detect = 0; line_dp = 1; line_dm = 0; #2;
    chk("R5 J state", reg_rdata[11:10], 2'b10);
    wr(16'h0100); wr(16'h0000);
    repeat (TAIL) @(negedge clk);
    chk("R9 reset ended", reset_active, 0);
    chk("R9 no enable", port_en, 0);
    chk("R9 owner unchanged", port_owner, 0);

    // Low-speed: K state, software releases ownership
    line_dp = 0; line_dm = 1; #2;
    chk("R5 K state", reg_rdata[11:10], 2'b01);
    wr(16'h2000);
    chk("R3 handed to companion", port_owner, 1);
    wr(16'h0000);

    // Halted hold during tail
    hs_detect = 1;
    wr(16'h0100);
    halted = 1;
    wr(16'h0000);
    repeat (20) @(negedge clk);
    chk("R10 bit held while halted", reset_active, 1);
    chk("R10 no drive while halted", drive_reset, 0);
    halted = 0;
    repeat (TAIL - 1) @(negedge clk);
    chk("R10 tail resumed, still held", reset_active, 1);
    @(negedge clk);
    chk("R10 tail done", reset_active, 0);
    chk("R8 enable after halted tail", port_en, 1);

    // Reset start with enable bit set in the write still disables
    wr(16'h0104);
    chk("R6 start clears enable", port_en, 0);
    wr(16'h0000);
    repeat (TAIL) @(negedge clk);
    chk("R8 final enable", port_en, 1);

    finish_run();
  end
endmodule